// File: doc/BRIEF.md
# Per-Sector Flash Write-Protection Manager

This block holds the write-protection state of every sector of a flash array of 4M words by 16 bits. The array has sectors of two sizes: eight small sectors of 4K words and 127 large sectors of 32K words, 135 in all. A strap input places the small sectors either at address zero (bottom-boot) or at the top of the address space (top-boot). Any word address is decoded to the index of the sector that contains it. Indices count upward from address zero.

Each sector is in one of three states: unlocked, locked or locked-down. A command strobe with an opcode and an address changes the state of the sector that contains that address. A separate query address reads back that sector's state. It also produces a write-permit flag that the program and erase sequencer consults. A program-voltage lockout input withdraws permission from every sector at once. Reset puts every sector in the locked state.

Top module: `flash_sector_guard`

## Requirements
- R1: After reset every sector reads back as locked (code 01) and the write-permit output is low.
- R2: With the strap low (bottom-boot), addresses 0x000000 to 0x007FFF form eight 4K-word sectors (indices 0 to 7). Each following 32K-word range is one sector (indices 8 to 134).
- R3: With the strap high (top-boot), addresses 0x000000 to 0x3F7FFF form 127 sectors of 32K words (indices 0 to 126). Addresses 0x3F8000 to 0x3FFFFF form eight 4K-word sectors (indices 127 to 134).
- R4: The state output gives the code of the sector that contains the query address, with no register delay: 00 unlocked, 01 locked, 11 locked-down.
- R5: Unlock (opcode 10) moves a locked sector to unlocked. Every command is visible at the query port in the cycle right after the clock edge that samples the strobe.
- R6: Lock (opcode 01) moves an unlocked sector to locked. It leaves a locked-down sector locked-down.
- R7: Lock-down (opcode 11) moves a sector from unlocked or from locked to locked-down.
- R8: A locked-down sector ignores unlock commands and stays locked-down until reset.
- R9: The write-permit output is high only when the queried sector is unlocked and the lockout input is low.
- R10: While the lockout input is high, write-permit is low for every address. The state readback does not change.
- R11: A command has no effect when the strobe is low or when the opcode is 00.
- R12: A command changes only the sector that contains its address. Neighbouring sectors keep their state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; locks all sectors |
| boot_top | input | 1 | Layout strap: 1 places small sectors at the top, 0 at the bottom |
| vpp_lock | input | 1 | Program-voltage lockout; high blocks all writes |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command opcode: 00 none, 01 lock, 10 unlock, 11 lock-down |
| cmd_addr | input | 22 | Word address selecting the target sector |
| qry_addr | input | 22 | Word address to query |
| qry_state | output | 2 | Protection code of the queried sector |
| wr_permit | output | 1 | High when a program or erase to qry_addr may proceed |

## Verification
The sector states are the only registers. A command driven before a rising edge is therefore due at the query outputs right after that edge. Query and lockout changes are due in the same cycle, through combinational logic only. The bench drives every input on the falling edge, so a command is sampled at the next rising edge. The query for it is driven on the falling edge after that, and the monitor compares 1 ns later. Each check therefore observes the state one clock edge after its command, with no slack that could hide an extra pipeline stage. Probes on both sides of each sector boundary, in both layouts, pin down the decode.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;

    localparam int FP_ADDR_W  = 22;
    localparam int FP_SMALL_W = 12;
    localparam int FP_LARGE_W = 15;
    localparam int FP_N_SMALL = 8;
    localparam int FP_N_LARGE = ((1 << FP_ADDR_W) - FP_N_SMALL * (1 << FP_SMALL_W)) >> FP_LARGE_W;
    localparam int FP_N_SECT  = FP_N_SMALL + FP_N_LARGE;
    localparam int FP_IDX_W   = $clog2(FP_N_SECT);

    typedef enum logic [1:0] {
        ST_UNLOCKED = 2'b00,
        ST_LOCKED   = 2'b01,
        ST_LOCKDOWN = 2'b11
    } prot_state_e;

    typedef enum logic [1:0] {
        OP_NONE     = 2'b00,
        OP_LOCK     = 2'b01,
        OP_UNLOCK   = 2'b10,
        OP_LOCKDOWN = 2'b11
    } prot_op_e;

    // Transition rule for a single sector
    function automatic prot_state_e prot_next(prot_state_e cur, prot_op_e op);
        prot_state_e nxt;
        nxt = cur;
        case (op)
            OP_LOCK:     if (cur != ST_LOCKDOWN) nxt = ST_LOCKED;
            OP_UNLOCK:   if (cur != ST_LOCKDOWN) nxt = ST_UNLOCKED;
            OP_LOCKDOWN: nxt = ST_LOCKDOWN;
            default:     nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/flash_sector_decode.sv
module flash_sector_decode #(
    parameter int ADDR_W  = flash_prot_pkg::FP_ADDR_W,
    parameter int SMALL_W = flash_prot_pkg::FP_SMALL_W,
    parameter int LARGE_W = flash_prot_pkg::FP_LARGE_W,
    parameter int N_SMALL = flash_prot_pkg::FP_N_SMALL,
    parameter int IDX_W   = flash_prot_pkg::FP_IDX_W
) (
    input  logic              top_layout,
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    // The small sectors together fill exactly one large-sector slot.
    localparam int SLOT_W = ADDR_W - LARGE_W;
    localparam int SUB_W  = LARGE_W - SMALL_W;

    logic [SLOT_W-1:0] slot;
    logic [SUB_W-1:0]  sub;

    assign slot = addr[ADDR_W-1:LARGE_W];
    assign sub  = addr[LARGE_W-1:SMALL_W];

    always_comb begin
        if (top_layout) begin
            // Last slot holds the small sectors; they follow the large ones.
            if (slot == {SLOT_W{1'b1}})
                idx = IDX_W'(slot) + IDX_W'(sub);
            else
                idx = IDX_W'(slot);
        end else begin
            // First slot holds the small sectors; large ones are shifted up.
            if (slot == '0)
                idx = IDX_W'(sub);
            else
                idx = IDX_W'(slot) + IDX_W'(N_SMALL - 1);
        end
    end

endmodule

// File: rtl/flash_sector_cell.sv
module flash_sector_cell
    import flash_prot_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hit,
    input  prot_op_e    op,
    output prot_state_e state
);
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_LOCKED;
        else if (hit)
            state <= prot_next(state, op);
    end
endmodule

// File: rtl/flash_sector_guard.sv
module flash_sector_guard
    import flash_prot_pkg::*;
#(
    parameter int ADDR_W  = FP_ADDR_W,
    parameter int SMALL_W = FP_SMALL_W,
    parameter int LARGE_W = FP_LARGE_W,
    parameter int N_SMALL = FP_N_SMALL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_top,
    input  logic              vpp_lock,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [ADDR_W-1:0] qry_addr,
    output logic [1:0]        qry_state,
    output logic              wr_permit
);
    localparam int N_LARGE = ((1 << ADDR_W) - N_SMALL * (1 << SMALL_W)) >> LARGE_W;
    localparam int N_SECT  = N_SMALL + N_LARGE;
    localparam int IDX_W   = $clog2(N_SECT);

    logic [IDX_W-1:0] cmd_idx;
    logic [IDX_W-1:0] qry_idx;
    prot_state_e      sect_st [N_SECT];
    prot_state_e      sel_st;

    flash_sector_decode #(
        .ADDR_W(ADDR_W), .SMALL_W(SMALL_W), .LARGE_W(LARGE_W),
        .N_SMALL(N_SMALL), .IDX_W(IDX_W)
    ) u_cmd_dec (
        .top_layout(boot_top),
        .addr      (cmd_addr),
        .idx       (cmd_idx)
    );

    flash_sector_decode #(
        .ADDR_W(ADDR_W), .SMALL_W(SMALL_W), .LARGE_W(LARGE_W),
        .N_SMALL(N_SMALL), .IDX_W(IDX_W)
    ) u_qry_dec (
        .top_layout(boot_top),
        .addr      (qry_addr),
        .idx       (qry_idx)
    );

    for (genvar i = 0; i < N_SECT; i++) begin : g_sect
        logic hit;
        assign hit = cmd_valid && (cmd_idx == IDX_W'(i));
        flash_sector_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .hit  (hit),
            .op   (prot_op_e'(cmd_op)),
            .state(sect_st[i])
        );
    end

    always_comb begin
        sel_st = ST_LOCKED;
        for (int k = 0; k < N_SECT; k++) begin
            if (qry_idx == IDX_W'(k))
                sel_st = sect_st[k];
        end
    end

    assign qry_state = sel_st;
    assign wr_permit = !vpp_lock && (sel_st == ST_UNLOCKED);

endmodule

// File: rtl/flash_sector_guard_chk.sv
module flash_sector_guard_chk #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst,
    input logic              boot_top,
    input logic              vpp_lock,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [ADDR_W-1:0] qry_addr,
    input logic [1:0]        qry_state,
    input logic              wr_permit
);
    // R1
    a_r1_reset_locked: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (qry_state == 2'b01 && !wr_permit));

    // R4
    a_r4_legal_code: assert property (@(posedge clk) disable iff (rst)
        qry_state != 2'b10);

    // R7
    a_r7_lockdown_applies: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cmd_valid && cmd_op == 2'b11 && cmd_addr == qry_addr)
         && $stable(qry_addr) && $stable(boot_top)) |-> qry_state == 2'b11);

    // R8
    a_r8_lockdown_sticky: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(qry_state == 2'b11)
         && $stable(qry_addr) && $stable(boot_top)) |-> qry_state == 2'b11);

    // R10
    a_r10_lockout_blocks: assert property (@(posedge clk) disable iff (rst)
        vpp_lock |-> !wr_permit);

    // R9
    a_r9_permit_needs_unlocked: assert property (@(posedge clk) disable iff (rst)
        wr_permit |-> (qry_state == 2'b00 && !vpp_lock));

endmodule

bind flash_sector_guard flash_sector_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .boot_top (boot_top),
    .vpp_lock (vpp_lock),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_addr (cmd_addr),
    .qry_addr (qry_addr),
    .qry_state(qry_state),
    .wr_permit(wr_permit)
);

// File: tb/tb_flash_sector_guard.sv
`timescale 1ns/1ps
module tb_flash_sector_guard;

    localparam int AW = 22;
    localparam int NS = 135;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          boot_top = 1'b0;
    logic          vpp_lock = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [AW-1:0] cmd_addr = '0;
    logic [AW-1:0] qry_addr = '0;
    logic [1:0]    qry_state;
    logic          wr_permit;

    always #2 clk = ~clk;

    flash_sector_guard dut (
        .clk(clk), .rst(rst), .boot_top(boot_top), .vpp_lock(vpp_lock),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .qry_addr(qry_addr), .qry_state(qry_state), .wr_permit(wr_permit)
    );

    typedef struct {
        logic [AW-1:0] addr;
        logic [1:0]    st;
        logic          permit;
        string         tag;
    } exp_item_t;

    exp_item_t   sb_q [$];
    logic [1:0]  model [NS];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    function automatic int bench_sector(int a, bit top);
        if (top) begin
            if (a >= 32'h3F8000) return 127 + (a - 32'h3F8000) / 4096;
            return a / 32768;
        end
        if (a < 32'h8000) return a / 4096;
        return 8 + (a - 32'h8000) / 32768;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NS; i++) model[i] = 2'b01;
    endtask

    task automatic do_cmd(bit strobe, logic [1:0] op, int a);
        int s;
        @(negedge clk);
        cmd_valid = strobe;
        cmd_op    = op;
        cmd_addr  = AW'(a);
        if (strobe) begin
            s = bench_sector(a, boot_top);
            case (op)
                2'b01: if (model[s] != 2'b11) model[s] = 2'b01;
                2'b10: if (model[s] != 2'b11) model[s] = 2'b00;
                2'b11: model[s] = 2'b11;
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        cmd_op    = 2'b00;
    endtask

    task automatic probe(int a, bit lockout, string tag);
        exp_item_t it;
        @(negedge clk);
        qry_addr = AW'(a);
        vpp_lock = lockout;
        it.addr   = AW'(a);
        it.st     = model[bench_sector(a, boot_top)];
        it.permit = (it.st == 2'b00) && !lockout;
        it.tag    = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compares each expected item 1 ns after it is driven
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                n_chk++;
                if (qry_state !== it.st || wr_permit !== it.permit) begin
                    n_fail++;
                    $display("FAIL %s addr=%06h state=%b permit=%b expected state=%b permit=%b",
                             it.tag, it.addr, qry_state, wr_permit, it.st, it.permit);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: every sector locked after reset
        probe(32'h000000, 1'b0, "R1 reset bottom");
        probe(32'h3FFFFF, 1'b0, "R1 reset top");
        probe(32'h123456, 1'b0, "R1 reset mid");

        // R5 R2 R9: unlock small sector 1, next query reflects it
        do_cmd(1'b1, 2'b10, 32'h001000);
        probe(32'h001FFF, 1'b0, "R5 R9 unlock no latency");
        probe(32'h000FFF, 1'b0, "R2 R12 small sector 0 untouched");
        probe(32'h002000, 1'b0, "R2 R12 small sector 2 untouched");

        // R2: large sector boundaries in bottom layout
        do_cmd(1'b1, 2'b10, 32'h010000);
        probe(32'h017FFF, 1'b0, "R2 large sector end");
        probe(32'h018000, 1'b0, "R2 R12 next large sector");
        probe(32'h00FFFF, 1'b0, "R2 R12 first large sector");

        // R10: lockout blocks permit, state still reads unlocked
        probe(32'h017FFF, 1'b1, "R10 lockout");
        probe(32'h001000, 1'b0, "R9 permit restored");

        // R11: strobe low or opcode none changes nothing
        do_cmd(1'b0, 2'b10, 32'h200000);
        probe(32'h200000, 1'b0, "R11 strobe low ignored");
        do_cmd(1'b1, 2'b00, 32'h010000);
        probe(32'h010000, 1'b0, "R11 opcode none ignored");

        // R6: lock re-locks
        do_cmd(1'b1, 2'b01, 32'h010005);
        probe(32'h010000, 1'b0, "R6 lock from unlocked");

        // R7: lockdown from unlocked
        do_cmd(1'b1, 2'b11, 32'h001000);
        probe(32'h001800, 1'b0, "R7 R4 lockdown from unlocked");
        // R8: unlock ignored, R6 lock leaves lockdown
        do_cmd(1'b1, 2'b10, 32'h001234);
        probe(32'h001000, 1'b0, "R8 unlock ignored");
        do_cmd(1'b1, 2'b01, 32'h001000);
        probe(32'h001000, 1'b0, "R6 lock keeps lockdown");
        // R7: lockdown from locked
        do_cmd(1'b1, 2'b11, 32'h3C0000);
        probe(32'h3C7FFF, 1'b0, "R7 lockdown from locked");

        // R1 R8: reset clears lockdown
        do_reset();
        probe(32'h001000, 1'b0, "R1 R8 reset clears lockdown");
        probe(32'h3C0000, 1'b0, "R1 reset clears lockdown large");

        // R3: top-boot layout
        boot_top = 1'b1;
        do_reset();
        do_cmd(1'b1, 2'b10, 32'h3F8000);
        probe(32'h3F8FFF, 1'b0, "R3 first small sector");
        probe(32'h3F9000, 1'b0, "R3 R12 second small sector");
        probe(32'h3F7FFF, 1'b0, "R3 R12 last large sector");
        do_cmd(1'b1, 2'b10, 32'h3FF000);
        probe(32'h3FFFFF, 1'b0, "R3 last small sector");
        do_cmd(1'b1, 2'b10, 32'h000000);
        probe(32'h007FFF, 1'b0, "R3 first large sector");
        probe(32'h008000, 1'b0, "R3 R12 second large sector");
        do_cmd(1'b1, 2'b11, 32'h3FC000);
        probe(32'h3FCFFF, 1'b1, "R4 R10 lockdown under lockout");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule